// File: doc/BRIEF.md
# Per-Signal Pattern Sense Matcher

This block watches a bus of monitored signals and, for each of several priority groups, reduces the bus to two bits: one that is true when every enabled signal agrees with its programmed sense (exact-pattern match) and one that is true when any enabled signal agrees (any-bit match). Each signal has a 2-bit select code per group. The code senses the signal as active-high or active-low, or marks the signal as neutral for the reductions. One set of configuration words can therefore express both kinds of match. The two results of every group feed a condition decoder further down the chain.

Configuration arrives through a plain write port with address, data and write enable. Each group owns `N_REG` 32-bit words, and each word covers eight signals. The group results are registered. Monitored signals and configuration both take effect on the result one clock edge after they are presented.

Top module: `pattern_sense_matcher`

## Requirements
- R1: While `rst` is high at a clock edge, every configuration word and both outputs of every group are cleared to 0 at that edge. With the cleared configuration, a group yields `grp_and`=1 and `grp_or`=0 for any input.
- R2: Select code 2'b11 senses a signal as active-high: the signal's match is `sig_in` itself, and that match feeds both the AND and the OR reduction of the group.
- R3: Select code 2'b10 senses a signal as active-low: the signal's match is the inverse of `sig_in`, and that match feeds both reductions.
- R4: Select codes 2'b00 and 2'b01 make a signal neutral: it contributes 1 to the AND reduction and 0 to the OR reduction, whatever its value.
- R5: `grp_and[g]` is the AND of all contributions of group g, and `grp_or[g]` is the OR of all contributions of group g.
- R6: Configuration word `a` belongs to group `a / N_REG`, word `a % N_REG` of that group. Word w covers signals 8w..8w+7. The code for signal 8w+k sits in bits 4k+1:4k, and bits 4k+3:4k+2 are ignored.
- R7: A code field whose signal position is at or above `N_SIG` is ignored, and that position acts as neutral.
- R8: A write whose address is at or above `N_GRP*N_REG` changes no configuration word.
- R9: The outputs change only at a clock edge. The result present after edge t is computed from the `sig_in` value sampled at edge t and from the configuration held before edge t, so a write at edge t first affects the result after edge t+1.
- R10: A write to one group's words leaves the results of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration word address (one spare bit above the valid range) |
| cfg_wdata | input | 32 | Configuration write data |
| sig_in | input | N_SIG | Monitored signals |
| grp_and | output | N_GRP | Registered AND result per group |
| grp_or | output | N_GRP | Registered OR result per group |

## Verification
A configuration write and a change of the monitored signals can fall in the same clock edge. The bench sweeps every value of a 12-signal bus through four groups. During the sweep it places writes in the same cycle as new signal values. Each result after the edge must come from the old configuration and the new signals, and the following result from the new configuration. The outputs are also sampled just after each input change and before the next edge, to confirm that they still hold the previous result.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int FIELDS_PER_WORD = 8;
  localparam int FIELD_STRIDE    = 4;
  localparam int WORD_W          = 32;

  typedef enum logic [1:0] {
    SEL_OR_NEUTRAL  = 2'b00,
    SEL_AND_NEUTRAL = 2'b01,
    SEL_ACTIVE_LOW  = 2'b10,
    SEL_ACTIVE_HIGH = 2'b11
  } sel_code_e;
endpackage

// File: rtl/psm_sense_cell.sv
module psm_sense_cell
  import psm_pkg::*;
(
  input  logic       sig,
  input  logic [1:0] code,
  output logic       and_c,
  output logic       or_c
);
  always_comb begin
    case (sel_code_e'(code))
      SEL_ACTIVE_HIGH: begin and_c = sig;  or_c = sig;  end
      SEL_ACTIVE_LOW:  begin and_c = !sig; or_c = !sig; end
      default:         begin and_c = 1'b1; or_c = 1'b0; end
    endcase
  end
endmodule

// File: rtl/psm_cfg_bank.sv
module psm_cfg_bank
  import psm_pkg::*;
#(
  parameter int N_CFG  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [WORD_W-1:0]              cfg_wdata,
  output logic [N_CFG-1:0][WORD_W-1:0]   cfg_q
);
  localparam int IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_CFG - 1);

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = cfg_we && (cfg_addr <= LAST_ADDR);
  assign idx = cfg_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (hit) begin
      cfg_q[idx] <= cfg_wdata;
    end
  end

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_addr > LAST_ADDR)) |=> $stable(cfg_q)); // R8

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cfg_q[$past(idx)] == $past(cfg_wdata))); // R6
endmodule

// File: rtl/psm_group.sv
module psm_group
  import psm_pkg::*;
#(
  parameter int N_SIG = 12,
  parameter int N_REG = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_REG-1:0][WORD_W-1:0]  cfg,
  input  logic [N_SIG-1:0]              sig,
  output logic                          and_q,
  output logic                          or_q
);
  localparam int N_POS = N_REG * FIELDS_PER_WORD;

  logic [N_POS-1:0] and_c;
  logic [N_POS-1:0] or_c;
  logic [N_POS-1:0] sense_en;
  logic             cfg_unused_bits;

  assign cfg_unused_bits = ^cfg;

  for (genvar p = 0; p < N_POS; p++) begin : g_pos
    if (p < N_SIG) begin : g_live
      localparam int W = p / FIELDS_PER_WORD;
      localparam int B = FIELD_STRIDE * (p % FIELDS_PER_WORD);
      psm_sense_cell u_cell (
        .sig   (sig[p]),
        .code  (cfg[W][B +: 2]),
        .and_c (and_c[p]),
        .or_c  (or_c[p])
      );
      assign sense_en[p] = cfg[W][B + 1];
    end else begin : g_pad
      assign and_c[p]    = 1'b1;
      assign or_c[p]     = 1'b0;
      assign sense_en[p] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q <= 1'b0;
      or_q  <= 1'b0;
    end else begin
      and_q <= &and_c;
      or_q  <= |or_c;
    end
  end

  AST_CELL_CONTRIB: assert property (@(posedge clk) disable iff (rst)
    ((or_c & ~and_c) == '0)); // R4

  AST_OR_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst)
    or_q |-> $past(|sense_en)); // R5
endmodule

// File: rtl/pattern_sense_matcher.sv
module pattern_sense_matcher
  import psm_pkg::*;
#(
  parameter int N_SIG = 12,
  parameter int N_GRP = 4,
  localparam int N_REG  = (N_SIG + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
  localparam int N_CFG  = N_GRP * N_REG,
  localparam int ADDR_W = ((N_CFG > 1) ? $clog2(N_CFG) : 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [N_SIG-1:0]  sig_in,
  output logic [N_GRP-1:0]  grp_and,
  output logic [N_GRP-1:0]  grp_or
);
  logic [N_CFG-1:0][WORD_W-1:0] cfg_q;

  psm_cfg_bank #(.N_CFG(N_CFG), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    psm_group #(.N_SIG(N_SIG), .N_REG(N_REG)) u_group (
      .clk   (clk),
      .rst   (rst),
      .cfg   (cfg_q[g*N_REG +: N_REG]),
      .sig   (sig_in),
      .and_q (grp_and[g]),
      .or_q  (grp_or[g])
    );
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> ((grp_and == '0) && (grp_or == '0))); // R1
endmodule

// File: tb/pattern_sense_matcher_tb.sv
module pattern_sense_matcher_tb;
  localparam int NS = 12;
  localparam int NG = 4;
  localparam int NR = 2;
  localparam int NC = NG * NR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NS-1:0] sig_in = '0;
  logic [NG-1:0] grp_and, grp_or;

  int checks = 0;
  int errors = 0;
  logic [31:0] cfg_m [NC];
  logic [2*NG-1:0] prev_exp;

  always #10 clk = ~clk;

  pattern_sense_matcher #(.N_SIG(NS), .N_GRP(NG)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sig_in(sig_in), .grp_and(grp_and), .grp_or(grp_or)
  );

  function automatic logic [2*NG-1:0] model(input logic [NS-1:0] s);
    logic [NG-1:0] a, o;
    for (int g = 0; g < NG; g++) begin
      a[g] = 1'b1; o[g] = 1'b0;
      for (int p = 0; p < NS; p++) begin
        logic [1:0] c;
        logic m;
        c = cfg_m[g*NR + p/8][4*(p%8) +: 2];
        if (c[1]) begin
          m = c[0] ? s[p] : !s[p];
          a[g] = a[g] & m;
          o[g] = o[g] | m;
        end
      end
    end
    return {a, o};
  endfunction

  task automatic check(input logic [2*NG-1:0] act, input logic [2*NG-1:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s and/or act=%b exp=%b", req, act, exp);
    end
  endtask

  // Called at a negedge: drive inputs, check outputs hold before the edge,
  // then check the edge result (old config, new signals) and apply the write.
  task automatic cyc(input logic [NS-1:0] s, input logic we, input logic [3:0] a,
                     input logic [31:0] d, input string req);
    logic [2*NG-1:0] e;
    sig_in = s; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    e = model(s);
    #1;
    check({grp_and, grp_or}, prev_exp, "R9");
    @(negedge clk);
    check({grp_and, grp_or}, e, req);
    if (we && a < 4'(NC)) cfg_m[a[2:0]] = d;
    prev_exp = e;
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) cfg_m[i] = '0;
    sig_in = 12'hA5C;
    repeat (3) @(negedge clk);
    check({grp_and, grp_or}, '0, "R1");
    rst = 1'b0;
    prev_exp = '0;
    // R1: cleared config gives AND=1, OR=0 for any input
    cyc(12'hFFF, 1'b0, 4'd0, 32'h0, "R1");
    cyc(12'h000, 1'b0, 4'd0, 32'h0, "R1");
    // Group 0: exact 1010 on signals 3..0, rest neutral (R2 R3 R4 R6)
    cyc(12'h00A, 1'b1, 4'd0, 32'h11113232, "R6");
    cyc(12'h00A, 1'b1, 4'd1, 32'h11111111, "R6");
    // Group 1: any of signals 0..3 high (R2)
    cyc(12'h001, 1'b1, 4'd2, 32'h00003333, "R10");
    cyc(12'h000, 1'b1, 4'd3, 32'h00000000, "R10");
    // Group 2: active-low with ignored upper bits, mixed codes (R3 R6)
    cyc(12'h000, 1'b1, 4'd4, 32'hCCCCEEEE, "R10");
    // word 1: codes for signals 8..11 plus fields past N_SIG (R7)
    cyc(12'h123, 1'b1, 4'd5, 32'hABCD3322, "R7");
    // Group 3: all active-high, pad fields sensing (R7)
    cyc(12'h456, 1'b1, 4'd6, 32'h33333333, "R10");
    cyc(12'hFFF, 1'b1, 4'd7, 32'h33333333, "R7");
    // Out-of-range writes must change nothing (R8)
    cyc(12'h00A, 1'b1, 4'd8, 32'h0, "R8");
    cyc(12'h00A, 1'b1, 4'd15, 32'hFFFFFFFF, "R8");
    cyc(12'hFFF, 1'b0, 4'd0, 32'h0, "R8");
    // Full sweep, with same-cycle writes in the middle (R5 R9)
    for (int v = 0; v < 4096; v++) begin
      if (v == 1500)      cyc(NS'(v), 1'b1, 4'd2, 32'h22220000, "R9");
      else if (v == 2600) cyc(NS'(v), 1'b1, 4'd12, 32'h0, "R8");
      else if (v == 3000) cyc(NS'(v), 1'b1, 4'd0, 32'h00001111, "R9");
      else                cyc(NS'(v), 1'b0, 4'd0, 32'h0, "R5");
    end
    // Second configuration: pattern in word 1, OR over active-low (R3 R5)
    cyc(12'h000, 1'b1, 4'd0, 32'h11111111, "R6");
    cyc(12'h000, 1'b1, 4'd1, 32'h11113232, "R6");
    cyc(12'h000, 1'b1, 4'd6, 32'h22222222, "R3");
    cyc(12'h000, 1'b1, 4'd7, 32'h00002222, "R3");
    for (int v = 0; v < 4096; v++) begin
      cyc(NS'(v ^ 12'h5A5), 1'b0, 4'd0, 32'h0, (v % 2 == 0) ? "R2" : "R3");
    end
    // Reset mid-run clears outputs and config (R1)
    rst = 1'b1;
    @(negedge clk);
    check({grp_and, grp_or}, '0, "R1");
    rst = 1'b0;
    for (int i = 0; i < NC; i++) cfg_m[i] = '0;
    prev_exp = '0;
    cyc(12'h00A, 1'b0, 4'd0, 32'h0, "R1");
    cyc(12'h3C3, 1'b0, 4'd0, 32'h0, "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule